// File: doc/BRIEF.md
# Ethernet controller register and interrupt unit

This unit is the software-visible register file of a Fast Ethernet DMA controller, plus the logic that turns latched events into interrupt lines. A processor reaches it over a simple 32-bit bus with a 10-bit byte offset. Each access is a single-cycle strobe. Read data and the error flag come back one cycle after the strobe. The unit holds the event and mask registers, the controller control word, receive and transmit configuration, FIFO settings, the station address, and the base addresses of the receive and transmit descriptor rings.

The descriptor engines sit beside it. They receive a one-cycle transmit kick, a one-cycle receive-activate request and pointer-reload pulses. They report back through per-bit event-set pulses and through set/clear inputs for the receive-active flag. Thirteen level interrupt lines each carry one masked event bit, in a fixed order chosen for the interrupt controller rather than by bit position. Registers for the management interface, the statistics counters and the multicast hash accept writes but keep nothing.

Top module: `enet_csr_irq`

## Requirements
- R1: After hardware reset, the receive configuration register (offset 0x084) reads 0x05EE0001 and the receive FIFO start register (0x150) reads 0x00000500. Event (0x004), mask (0x008) and control (0x024) read 0. All interrupt lines are low.
- R2: A write to the event register (0x004) clears exactly those event bits that are 1 in the written value. The mask register (0x008) reads back what was written.
- R3: When an engine event-set pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R4: Line k of irq_o equals bit B(k) of (event AND mask), one clock after those registers change. B(0..12) = 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R5: Writing the control register with bit 0 set clears event, mask, control, MII speed (0x044), transmit control (0x0C4), FIFO watermark (0x144) and the receive-active flag. It also reloads receive configuration with 0x05EE0001 and FIFO start with 0x500. The station address and descriptor bases are kept.
- R6: Reading 0x010 returns 0x01000000 while receive is active, else 0. The engine may set the flag only while control bit 1 (enable) is 1. Any control write that leaves bit 1 at 0 clears it.
- R7: A write to 0x010 while enabled and not receive-active gives a one-cycle rx_arm_o pulse in the cycle after the write. Otherwise it gives none.
- R8: A write to 0x014 while enabled gives a one-cycle tx_kick_o pulse in the cycle after the write. While disabled it gives none. 0x014 always reads 0.
- R9: A write to transmit control (0x0C4) with bit 0 set sets event bit 28 at once. With bit 0 clear, event bit 28 is left alone.
- R10: Stored values are masked as follows. 0x084 keeps value & 0x07FF003F. 0x044 keeps value & 0xFE. 0x144 keeps value & 0x3. 0x188 keeps value & 0x7F0. 0x150 stores (value & 0x3FC) | 0x400.
- R11: The ring bases at 0x180 (receive) and 0x184 (transmit) store the value with bits [1:0] cleared. Each write pulses the matching pointer-load output for one cycle after the write.
- R12: 0x0E4 holds station address bytes 0..3, byte 0 in bits [31:24]. 0x0E8 holds bytes 4 and 5 in bits [31:16] and reads 0x8808 in bits [15:0]. station_addr_o is byte 0 down to byte 5. 0x0EC reads 0x00010000 and 0x14C reads 0x00000600, whatever is written.
- R13: An access to an offset outside the decoded set reads 0, changes nothing and raises bus_err_o for one cycle. Writes to 0x040, 0x064 and 0x118..0x124 are discarded, and those offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| bus_err_o | output | 1 | Undecoded-offset flag, the cycle after the strobe |
| evt_set_i | input | 32 | Per-bit event-set pulses from the engines |
| rx_active_set_i | input | 1 | Engine found a free receive descriptor |
| rx_active_clr_i | input | 1 | Engine ran out of receive descriptors |
| irq_o | output | 13 | Level interrupt lines |
| tx_kick_o | output | 1 | Transmit engine start pulse |
| rx_arm_o | output | 1 | Receive engine descriptor-check request |
| rx_ring_base_o | output | 32 | Receive ring base address |
| tx_ring_base_o | output | 32 | Transmit ring base address |
| rx_ptr_load_o | output | 1 | Reload receive current pointer from base |
| tx_ptr_load_o | output | 1 | Reload transmit current pointer from base |
| mac_enable_o | output | 1 | Controller enable (control bit 1) |
| rx_cfg_o | output | 32 | Receive configuration word |
| rx_buf_max_o | output | 32 | Largest receive buffer size |
| station_addr_o | output | 48 | Station address, byte 0 in the top bits |

## Verification
The bench walks the full line map bit by bit. A design that wired a line by bit position, or swapped two entries, lights the wrong line for the first affected event. It drives a clear and an engine set into the same event bit in one cycle, where a clear-wins design loses the event. It checks that a soft reset puts back the two non-zero configuration values while keeping the station address; a design that zeroed everything would read 0 where 0x05EE0001 belongs. It also checks the gating of kick and activate pulses on enable and receive-active, where an ungated design would start an engine while disabled or re-arm an already active receiver.

// File: rtl/enet_csr_pkg.sv
// Shared constants, register identifiers and the interrupt line map for the
// Ethernet register/interrupt unit. Assumes 32-bit data and 10-bit offsets.
package enet_csr_pkg;

    localparam int unsigned CSR_AW  = 10;
    localparam int unsigned CSR_DW  = 32;
    localparam int unsigned NUM_IRQ = 13;

    // Control word bit positions
    localparam int unsigned CTRL_SOFTRST_BIT = 0;
    localparam int unsigned CTRL_ENABLE_BIT  = 1;
    // Event raised by a graceful-stop request
    localparam int unsigned GRACE_EVT_BIT    = 28;
    // Bit carrying receive-active on read of the activate offset
    localparam int unsigned RXGO_ACTIVE_BIT  = 24;

    localparam logic [31:0] RXCFG_RST    = 32'h05EE_0001;
    localparam logic [31:0] RXCFG_KEEP   = 32'h07FF_003F;
    localparam logic [31:0] MDSPD_KEEP   = 32'h0000_00FE;
    localparam logic [31:0] FWM_KEEP     = 32'h0000_0003;
    localparam logic [31:0] BUFMAX_KEEP  = 32'h0000_07F0;
    localparam logic [31:0] FSTART_KEEP  = 32'h0000_03FC;
    localparam logic [31:0] FSTART_FORCE = 32'h0000_0400;
    localparam logic [31:0] FSTART_RST   = 32'h0000_0500;
    localparam logic [31:0] BASE_KEEP    = 32'hFFFF_FFFC;
    localparam logic [15:0] STA_HI_TAIL  = 16'h8808;
    localparam logic [31:0] PAUSE_RDVAL  = 32'h0001_0000;
    localparam logic [31:0] FBOUND_RDVAL = 32'h0000_0600;

    typedef enum logic [4:0] {
        ID_NONE, ID_EVENT, ID_MASK, ID_RXGO, ID_TXGO, ID_CTRL, ID_MGMT,
        ID_MDSPD, ID_CNTR, ID_RXCFG, ID_TXCFG, ID_STA_LO, ID_STA_HI,
        ID_PAUSE, ID_HASH, ID_FWM, ID_FBOUND, ID_FSTART, ID_RXBASE,
        ID_TXBASE, ID_BUFMAX
    } reg_id_e;

    // Map a byte offset to a register identifier
    function automatic reg_id_e decode_offset(input logic [CSR_AW-1:0] off);
        case (off)
            10'h004: return ID_EVENT;
            10'h008: return ID_MASK;
            10'h010: return ID_RXGO;
            10'h014: return ID_TXGO;
            10'h024: return ID_CTRL;
            10'h040: return ID_MGMT;
            10'h044: return ID_MDSPD;
            10'h064: return ID_CNTR;
            10'h084: return ID_RXCFG;
            10'h0C4: return ID_TXCFG;
            10'h0E4: return ID_STA_LO;
            10'h0E8: return ID_STA_HI;
            10'h0EC: return ID_PAUSE;
            10'h118, 10'h11C, 10'h120, 10'h124: return ID_HASH;
            10'h144: return ID_FWM;
            10'h14C: return ID_FBOUND;
            10'h150: return ID_FSTART;
            10'h180: return ID_RXBASE;
            10'h184: return ID_TXBASE;
            10'h188: return ID_BUFMAX;
            default: return ID_NONE;
        endcase
    endfunction

    // Event bit feeding each interrupt line (order fixed by the interrupt controller)
    function automatic int unsigned irq_src_bit(input int unsigned line);
        case (line)
            0:  return 27;
            1:  return 26;
            2:  return 19;
            3:  return 20;
            4:  return 25;
            5:  return 24;
            6:  return 23;
            7:  return 21;
            8:  return 31;
            9:  return 28;
            10: return 22;
            11: return 29;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/enet_csr_decode.sv
// Offset decoder: turns the bus byte offset into a register identifier.
// Assumes word-aligned offsets; any other offset decodes to ID_NONE.
module enet_csr_decode
    import enet_csr_pkg::*;
#(
    parameter int unsigned AW = CSR_AW
) (
    input  logic [AW-1:0] addr_i,
    output reg_id_e       id_o
);

    // Pure combinational lookup
    always_comb begin : p_decode
        id_o = decode_offset(addr_i);
    end

endmodule

// File: rtl/enet_evt_irq.sv
// Event and mask registers with the registered interrupt line driver.
// Assumes: clear and set arrive in the same cycle resolve with set winning;
// soft reset clears both registers but still lets set pulses through.
module enet_evt_irq
    import enet_csr_pkg::*;
#(
    parameter int unsigned DW     = CSR_DW,
    parameter int unsigned NLINES = NUM_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we_i,
    input  logic [DW-1:0]     clr_bits_i,
    input  logic              mask_we_i,
    input  logic [DW-1:0]     mask_wdata_i,
    input  logic              soft_rst_i,
    input  logic [DW-1:0]     set_bits_i,
    output logic [DW-1:0]     event_q,
    output logic [DW-1:0]     mask_q,
    output logic [NLINES-1:0] irq_o
);

    logic [DW-1:0] active;
    logic [DW-1:0] kept;

    // Bits surviving this cycle before new sets are merged
    always_comb begin : p_keep
        if (soft_rst_i)    kept = '0;
        else if (clr_we_i) kept = event_q & ~clr_bits_i;
        else               kept = event_q;
        active = event_q & mask_q;
    end

    // Event register: write-one-to-clear, set pulses dominate
    always_ff @(posedge clk) begin : p_event
        if (!rst_n) event_q <= '0;
        else        event_q <= kept | set_bits_i;
    end

    // Mask register: plain storage, cleared by soft reset
    always_ff @(posedge clk) begin : p_mask
        if (!rst_n)          mask_q <= '0;
        else if (soft_rst_i) mask_q <= '0;
        else if (mask_we_i)  mask_q <= mask_wdata_i;
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam int unsigned SRC = irq_src_bit(g);

        // One registered line per mapped event bit
        always_ff @(posedge clk) begin : p_line
            if (!rst_n) irq_o[g] <= 1'b0;
            else        irq_o[g] <= active[SRC];
        end

        // R4: line follows its mapped masked event one clock later
        a_r4_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o[g] == $past(event_q[SRC] & mask_q[SRC])));
    end

    // R3: a set pulse is never lost to a same-cycle clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits_i != '0) |=> ((event_q & $past(set_bits_i)) == $past(set_bits_i)));

    // R2: cleared bits without a concurrent set read back as zero
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !soft_rst_i) |=> ((event_q & $past(clr_bits_i & ~set_bits_i)) == '0));

    // R5: soft reset with no pending set empties event and mask
    a_r5_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && (set_bits_i == '0)) |=> ((event_q == '0) && (mask_q == '0)));

endmodule

// File: rtl/enet_cfg_regs.sv
// Configuration registers, receive-active flag and engine strobes.
// Assumes one write per cycle, qualified by we_i and the decoded id_i.
module enet_cfg_regs
    import enet_csr_pkg::*;
#(
    parameter int unsigned DW = CSR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  reg_id_e       id_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rx_active_set_i,
    input  logic          rx_active_clr_i,
    output logic          soft_rst_o,
    output logic          grace_o,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] mdspd_q,
    output logic [DW-1:0] rxcfg_q,
    output logic [DW-1:0] txcfg_q,
    output logic [DW-1:0] fwm_q,
    output logic [DW-1:0] fstart_q,
    output logic [DW-1:0] rxbase_q,
    output logic [DW-1:0] txbase_q,
    output logic [DW-1:0] bufmax_q,
    output logic [DW-1:0] sta_lo_q,
    output logic [15:0]   sta_hi_q,
    output logic          rx_active_q,
    output logic          tx_kick_o,
    output logic          rx_arm_o,
    output logic          rx_ptr_load_o,
    output logic          tx_ptr_load_o
);

    logic enabled;
    logic ctrl_wr;

    // Decode strobes derived from the current write
    always_comb begin : p_strobes
        enabled    = ctrl_q[CTRL_ENABLE_BIT];
        ctrl_wr    = we_i && (id_i == ID_CTRL);
        soft_rst_o = ctrl_wr && wdata_i[CTRL_SOFTRST_BIT];
        grace_o    = we_i && (id_i == ID_TXCFG) && wdata_i[0];
    end

    // Register storage with per-register masking and soft reset
    always_ff @(posedge clk) begin : p_regs
        if (!rst_n) begin
            ctrl_q   <= '0;
            mdspd_q  <= '0;
            rxcfg_q  <= RXCFG_RST;
            txcfg_q  <= '0;
            fwm_q    <= '0;
            fstart_q <= FSTART_RST;
            rxbase_q <= '0;
            txbase_q <= '0;
            bufmax_q <= '0;
            sta_lo_q <= '0;
            sta_hi_q <= '0;
        end else if (soft_rst_o) begin
            ctrl_q   <= '0;
            mdspd_q  <= '0;
            rxcfg_q  <= RXCFG_RST;
            txcfg_q  <= '0;
            fwm_q    <= '0;
            fstart_q <= FSTART_RST;
        end else if (we_i) begin
            case (id_i)
                ID_CTRL:   ctrl_q   <= wdata_i;
                ID_MDSPD:  mdspd_q  <= wdata_i & MDSPD_KEEP;
                ID_RXCFG:  rxcfg_q  <= wdata_i & RXCFG_KEEP;
                ID_TXCFG:  txcfg_q  <= wdata_i;
                ID_FWM:    fwm_q    <= wdata_i & FWM_KEEP;
                ID_FSTART: fstart_q <= (wdata_i & FSTART_KEEP) | FSTART_FORCE;
                ID_RXBASE: rxbase_q <= wdata_i & BASE_KEEP;
                ID_TXBASE: txbase_q <= wdata_i & BASE_KEEP;
                ID_BUFMAX: bufmax_q <= wdata_i & BUFMAX_KEEP;
                ID_STA_LO: sta_lo_q <= wdata_i;
                ID_STA_HI: sta_hi_q <= wdata_i[31:16];
                default:   ;
            endcase
        end
    end

    // Receive-active flag: software disable wins, engine set needs enable
    always_ff @(posedge clk) begin : p_rx_active
        if (!rst_n)                                                rx_active_q <= 1'b0;
        else if (ctrl_wr && (soft_rst_o || !wdata_i[CTRL_ENABLE_BIT])) rx_active_q <= 1'b0;
        else if (rx_active_clr_i)                                  rx_active_q <= 1'b0;
        else if (rx_active_set_i && enabled)                       rx_active_q <= 1'b1;
    end

    // One-cycle strobes toward the descriptor engines
    always_ff @(posedge clk) begin : p_pulses
        if (!rst_n) begin
            tx_kick_o     <= 1'b0;
            rx_arm_o      <= 1'b0;
            rx_ptr_load_o <= 1'b0;
            tx_ptr_load_o <= 1'b0;
        end else begin
            tx_kick_o     <= we_i && (id_i == ID_TXGO) && enabled;
            rx_arm_o      <= we_i && (id_i == ID_RXGO) && enabled && !rx_active_q;
            rx_ptr_load_o <= we_i && (id_i == ID_RXBASE);
            tx_ptr_load_o <= we_i && (id_i == ID_TXBASE);
        end
    end

    // R6: receive cannot be active in the cycle after a disabled cycle
    a_r6_inactive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !rx_active_q);

    // R7: activate request only when enabled and idle
    a_r7_arm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arm_o |-> $past(enabled && !rx_active_q));

    // R8: transmit kick only when enabled
    a_r8_kick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick_o |-> $past(enabled));

    // R11: ring bases presented on reload are word aligned
    a_r11_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ptr_load_o || tx_ptr_load_o) |-> ((rxbase_q[1:0] == 2'b00) && (txbase_q[1:0] == 2'b00)));

endmodule

// File: rtl/enet_csr_irq.sv
// Top of the Ethernet register/interrupt unit: bus decode, read return,
// error flag and wiring between event logic and configuration registers.
// Assumes single-cycle access strobes; read data returns one cycle later.
module enet_csr_irq
    import enet_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [CSR_AW-1:0]  bus_addr_i,
    input  logic [CSR_DW-1:0]  bus_wdata_i,
    output logic [CSR_DW-1:0]  bus_rdata_o,
    output logic               bus_err_o,
    input  logic [CSR_DW-1:0]  evt_set_i,
    input  logic               rx_active_set_i,
    input  logic               rx_active_clr_i,
    output logic [NUM_IRQ-1:0] irq_o,
    output logic               tx_kick_o,
    output logic               rx_arm_o,
    output logic [CSR_DW-1:0]  rx_ring_base_o,
    output logic [CSR_DW-1:0]  tx_ring_base_o,
    output logic               rx_ptr_load_o,
    output logic               tx_ptr_load_o,
    output logic               mac_enable_o,
    output logic [CSR_DW-1:0]  rx_cfg_o,
    output logic [CSR_DW-1:0]  rx_buf_max_o,
    output logic [47:0]        station_addr_o
);

    reg_id_e           id;
    logic              we;
    logic              soft_rst;
    logic              grace;
    logic [CSR_DW-1:0] set_bits;
    logic [CSR_DW-1:0] event_q, mask_q;
    logic [CSR_DW-1:0] ctrl_q, mdspd_q, rxcfg_q, txcfg_q, fwm_q, fstart_q;
    logic [CSR_DW-1:0] rxbase_q, txbase_q, bufmax_q, sta_lo_q;
    logic [15:0]       sta_hi_q;
    logic              rx_active_q;
    logic [CSR_DW-1:0] rd_mux;

    enet_csr_decode #(.AW(CSR_AW)) u_dec (
        .addr_i (bus_addr_i),
        .id_o   (id)
    );

    // Write qualifier and merged event-set sources
    always_comb begin : p_wr_qual
        we       = bus_sel_i && bus_wr_i && (id != ID_NONE);
        set_bits = evt_set_i;
        set_bits[GRACE_EVT_BIT] = evt_set_i[GRACE_EVT_BIT] | grace;
    end

    enet_cfg_regs #(.DW(CSR_DW)) u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .we_i            (we),
        .id_i            (id),
        .wdata_i         (bus_wdata_i),
        .rx_active_set_i (rx_active_set_i),
        .rx_active_clr_i (rx_active_clr_i),
        .soft_rst_o      (soft_rst),
        .grace_o         (grace),
        .ctrl_q          (ctrl_q),
        .mdspd_q         (mdspd_q),
        .rxcfg_q         (rxcfg_q),
        .txcfg_q         (txcfg_q),
        .fwm_q           (fwm_q),
        .fstart_q        (fstart_q),
        .rxbase_q        (rxbase_q),
        .txbase_q        (txbase_q),
        .bufmax_q        (bufmax_q),
        .sta_lo_q        (sta_lo_q),
        .sta_hi_q        (sta_hi_q),
        .rx_active_q     (rx_active_q),
        .tx_kick_o       (tx_kick_o),
        .rx_arm_o        (rx_arm_o),
        .rx_ptr_load_o   (rx_ptr_load_o),
        .tx_ptr_load_o   (tx_ptr_load_o)
    );

    enet_evt_irq #(.DW(CSR_DW), .NLINES(NUM_IRQ)) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_we_i     (we && (id == ID_EVENT)),
        .clr_bits_i   (bus_wdata_i),
        .mask_we_i    (we && (id == ID_MASK)),
        .mask_wdata_i (bus_wdata_i),
        .soft_rst_i   (soft_rst),
        .set_bits_i   (set_bits),
        .event_q      (event_q),
        .mask_q       (mask_q),
        .irq_o        (irq_o)
    );

    // Read return selection by register identifier
    always_comb begin : p_rd_mux
        rd_mux = '0;
        case (id)
            ID_EVENT:  rd_mux = event_q;
            ID_MASK:   rd_mux = mask_q;
            ID_RXGO:   rd_mux[RXGO_ACTIVE_BIT] = rx_active_q;
            ID_CTRL:   rd_mux = ctrl_q;
            ID_MDSPD:  rd_mux = mdspd_q;
            ID_RXCFG:  rd_mux = rxcfg_q;
            ID_TXCFG:  rd_mux = txcfg_q;
            ID_STA_LO: rd_mux = sta_lo_q;
            ID_STA_HI: rd_mux = {sta_hi_q, STA_HI_TAIL};
            ID_PAUSE:  rd_mux = PAUSE_RDVAL;
            ID_FWM:    rd_mux = fwm_q;
            ID_FBOUND: rd_mux = FBOUND_RDVAL;
            ID_FSTART: rd_mux = fstart_q;
            ID_RXBASE: rd_mux = rxbase_q;
            ID_TXBASE: rd_mux = txbase_q;
            ID_BUFMAX: rd_mux = bufmax_q;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data and error flag
    always_ff @(posedge clk) begin : p_rd_ret
        if (!rst_n) begin
            bus_rdata_o <= '0;
            bus_err_o   <= 1'b0;
        end else begin
            bus_rdata_o <= (bus_sel_i && !bus_wr_i) ? rd_mux : '0;
            bus_err_o   <= bus_sel_i && (id == ID_NONE);
        end
    end

    // Configuration seen by the engines
    always_comb begin : p_outs
        rx_ring_base_o = rxbase_q;
        tx_ring_base_o = txbase_q;
        mac_enable_o   = ctrl_q[CTRL_ENABLE_BIT];
        rx_cfg_o       = rxcfg_q;
        rx_buf_max_o   = bufmax_q;
        station_addr_o = {sta_lo_q, sta_hi_q};
    end

    // R13: error flag only follows an access strobe
    a_r13_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> $past(bus_sel_i));

    // R1: read data is zero unless a read was issued the cycle before
    a_r1_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel_i && !bus_wr_i) |-> (bus_rdata_o == '0));

endmodule

// File: tb/sim_enet_csr_irq.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor pops and compares.
module sim_enet_csr_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] evt_set = '0;
    logic        rx_act_set = 1'b0;
    logic        rx_act_clr = 1'b0;
    logic [12:0] irq;
    logic        tx_kick, rx_arm, rx_load, tx_load, mac_en;
    logic [31:0] rx_base, tx_base, rx_cfg, rx_bufmax;
    logic [47:0] sta_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];
    logic        rd_pend = 1'b0;

    int line_map[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    always #2.5 clk = ~clk;

    enet_csr_irq u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_sel_i (bus_sel), .bus_wr_i (bus_wr), .bus_addr_i (bus_addr),
        .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata), .bus_err_o (bus_err),
        .evt_set_i (evt_set), .rx_active_set_i (rx_act_set), .rx_active_clr_i (rx_act_clr),
        .irq_o (irq), .tx_kick_o (tx_kick), .rx_arm_o (rx_arm),
        .rx_ring_base_o (rx_base), .tx_ring_base_o (tx_base),
        .rx_ptr_load_o (rx_load), .tx_ptr_load_o (tx_load),
        .mac_enable_o (mac_en), .rx_cfg_o (rx_cfg), .rx_buf_max_o (rx_bufmax),
        .station_addr_o (sta_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: note read strobes at the edge, compare returned data after it
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (q_exp.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: actual %h expected none", bus_rdata);
            end else begin
                check(q_tag.pop_front(), {32'h0, bus_rdata}, {32'h0, q_exp.pop_front()});
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_evt(input logic [31:0] bits);
        @(negedge clk);
        evt_set = bits;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {51'h0, irq}, 64'h0);
        rd(10'h084, 32'h05EE0001, "R1 rxcfg");
        rd(10'h150, 32'h00000500, "R1 fstart");
        rd(10'h004, 32'h0, "R1 event");
        rd(10'h008, 32'h0, "R1 mask");
        rd(10'h024, 32'h0, "R1 ctrl");

        // R12: station address and constant reads
        wr(10'h0E4, 32'h11223344);
        wr(10'h0E8, 32'h5566ABCD);
        rd(10'h0E4, 32'h11223344, "R12 sta lo");
        rd(10'h0E8, 32'h55668808, "R12 sta hi");
        check("R12 station out", {16'h0, sta_addr}, {16'h0, 48'h112233445566});
        wr(10'h0EC, 32'hFFFFFFFF);
        rd(10'h0EC, 32'h00010000, "R12 pause rd");
        rd(10'h14C, 32'h00000600, "R12 fbound rd");

        // R10: write masks
        wr(10'h084, 32'hFFFFFFFF); rd(10'h084, 32'h07FF003F, "R10 rxcfg");
        wr(10'h044, 32'hFFFFFFFF); rd(10'h044, 32'h000000FE, "R10 mdspd");
        wr(10'h144, 32'h000000FF); rd(10'h144, 32'h00000003, "R10 fwm");
        wr(10'h188, 32'hFFFFFFFF); rd(10'h188, 32'h000007F0, "R10 bufmax");
        wr(10'h150, 32'hFFFFFFFF); rd(10'h150, 32'h000007FC, "R10 fstart ones");
        wr(10'h150, 32'h00000000); rd(10'h150, 32'h00000400, "R10 fstart zero");

        // R11: ring bases and reload pulses
        wr(10'h180, 32'h12345677);
        check("R11 rx load", {63'h0, rx_load}, 64'h1);
        check("R11 rx base", {32'h0, rx_base}, {32'h0, 32'h12345674});
        @(negedge clk);
        check("R11 rx load drop", {63'h0, rx_load}, 64'h0);
        wr(10'h184, 32'hABCDEF03);
        check("R11 tx load", {63'h0, tx_load}, 64'h1);
        rd(10'h184, 32'hABCDEF00, "R11 tx base rd");

        // R2 / R4: events, mask, line mapping
        wr(10'h008, 32'h08000000);
        rd(10'h008, 32'h08000000, "R2 mask rd");
        pulse_evt(32'h48000000);
        @(negedge clk);
        check("R4 line0 only", {51'h0, irq}, 64'h1);
        rd(10'h004, 32'h48000000, "R2 event rd");
        wr(10'h008, 32'hFFFFFFFF);
        @(negedge clk);
        check("R4 lines 0 and 12", {51'h0, irq}, 64'h1001);
        wr(10'h004, 32'h08000000);
        rd(10'h004, 32'h40000000, "R2 w1c partial");
        check("R4 line12 only", {51'h0, irq}, 64'h1000);
        wr(10'h004, 32'hFFFFFFFF);
        for (int i = 0; i < 13; i++) begin
            pulse_evt(32'h1 << line_map[i]);
            @(negedge clk);
            check($sformatf("R4 map line %0d", i), {51'h0, irq}, 64'h1 << i);
            wr(10'h004, 32'h1 << line_map[i]);
        end
        @(negedge clk);
        check("R4 all clear", {51'h0, irq}, 64'h0);

        // R3: same-cycle set and clear on bit 25
        pulse_evt(32'h02000000);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h004; bus_wdata = 32'h02000000;
        evt_set = 32'h02000000;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
        rd(10'h004, 32'h02000000, "R3 set wins");
        wr(10'h004, 32'hFFFFFFFF);

        // R9: graceful stop event
        wr(10'h0C4, 32'h00000002);
        rd(10'h004, 32'h00000000, "R9 no grace on bit0 clear");
        wr(10'h0C4, 32'h00000001);
        rd(10'h004, 32'h10000000, "R9 grace event");
        wr(10'h004, 32'hFFFFFFFF);

        // R8 / R7: gated while disabled
        wr(10'h014, 32'h0);
        check("R8 no kick disabled", {63'h0, tx_kick}, 64'h0);
        wr(10'h010, 32'h0);
        check("R7 no arm disabled", {63'h0, rx_arm}, 64'h0);

        wr(10'h024, 32'h00000002);
        check("R6 enable out", {63'h0, mac_en}, 64'h1);
        wr(10'h014, 32'h0);
        check("R8 kick", {63'h0, tx_kick}, 64'h1);
        @(negedge clk);
        check("R8 kick one cycle", {63'h0, tx_kick}, 64'h0);
        rd(10'h014, 32'h0, "R8 txgo reads zero");
        wr(10'h010, 32'h0);
        check("R7 arm", {63'h0, rx_arm}, 64'h1);
        @(negedge clk);
        check("R7 arm one cycle", {63'h0, rx_arm}, 64'h0);
        rx_act_set = 1'b1;
        @(negedge clk);
        rx_act_set = 1'b0;
        rd(10'h010, 32'h01000000, "R6 active rd");
        wr(10'h010, 32'h0);
        check("R7 no arm when active", {63'h0, rx_arm}, 64'h0);
        wr(10'h024, 32'h00000000);
        rd(10'h010, 32'h00000000, "R6 cleared by disable");
        rx_act_set = 1'b1;
        @(negedge clk);
        rx_act_set = 1'b0;
        rd(10'h010, 32'h00000000, "R6 no set while disabled");

        // R5: soft reset
        wr(10'h024, 32'h00000002);
        rx_act_set = 1'b1;
        @(negedge clk);
        rx_act_set = 1'b0;
        wr(10'h008, 32'h0000FFFF);
        pulse_evt(32'h00F00000);
        wr(10'h084, 32'h00000005);
        wr(10'h044, 32'h00000010);
        wr(10'h0C4, 32'h00000004);
        wr(10'h144, 32'h00000001);
        wr(10'h024, 32'h00000003);
        rd(10'h004, 32'h0, "R5 event");
        rd(10'h008, 32'h0, "R5 mask");
        rd(10'h024, 32'h0, "R5 ctrl");
        rd(10'h010, 32'h0, "R5 rx active");
        rd(10'h084, 32'h05EE0001, "R5 rxcfg");
        rd(10'h150, 32'h00000500, "R5 fstart");
        rd(10'h044, 32'h0, "R5 mdspd");
        rd(10'h0C4, 32'h0, "R5 txcfg");
        rd(10'h144, 32'h0, "R5 fwm");
        rd(10'h0E4, 32'h11223344, "R5 station kept");
        rd(10'h180, 32'h12345674, "R5 base kept");

        // R13: undecoded and discarded offsets
        rd(10'h3FC, 32'h0, "R13 undecoded rd");
        check("R13 err", {63'h0, bus_err}, 64'h1);
        @(negedge clk);
        check("R13 err one cycle", {63'h0, bus_err}, 64'h0);
        wr(10'h006, 32'hFFFFFFFF);
        check("R13 err on write", {63'h0, bus_err}, 64'h1);
        rd(10'h004, 32'h0, "R13 misaligned write ignored");
        wr(10'h040, 32'hDEADBEEF); rd(10'h040, 32'h0, "R13 mgmt discarded");
        wr(10'h064, 32'hDEADBEEF); rd(10'h064, 32'h0, "R13 counters discarded");
        wr(10'h11C, 32'hDEADBEEF); rd(10'h11C, 32'h0, "R13 hash discarded");
        check("R13 no err decoded", {63'h0, bus_err}, 64'h0);

        repeat (2) @(negedge clk);
        if (q_exp.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard drain: actual %0d expected 0", q_exp.size());
        end
        done = 1'b1;
        finish_up();
    end

endmodule